// File: doc/BRIEF.md
# Window Threshold Watchdog Monitor

This block watches the stream of 10-bit conversion results leaving an analog-to-digital sequencer and flags every result that falls outside a programmable window. A value counts as outside when it is strictly below the low limit or strictly above the high limit. In the single-channel modes every result is checked. In the scan and buffered modes each entry (a channel number in scan, a buffer slot in buffered) has its own enable bit and its own sticky status bit, and a global flag summarises them.

The timing of the global flag and the interrupt depends on which interrupt sources are enabled. With only the watchdog interrupt enabled, the summary is raised when the sequence ends. With the watchdog and end-of-conversion interrupts both enabled, the first violation raises the flag and the interrupt at once, and it pulses a stop request so that the conversion engine halts continuous operation. With the watchdog interrupt disabled, the flags still record violations, but no interrupt or stop request is produced. Software clears the flags with write-one-to-clear strobes.

Top module: `awd_monitor`

## Requirements
- R1: A valid result is a violation exactly when it is less than `lo_thr` or greater than `hi_thr`. A result equal to either limit is not a violation.
- R2: In single mode (`mode`=0) and continuous mode (`mode`=1), every violating result sets `global_flag` on the next clock edge, regardless of `res_idx` and `entry_en`. If `awd_ie`=1, `irq` also pulses for one cycle. The `status` bits are never changed in these modes.
- R3: In scan mode (`mode`=2), a violating result with `entry_en[res_idx]`=1 sets `status[res_idx]` on the next clock edge.
- R4: In buffered mode (`mode`=3), the same per-entry set rule applies, with `res_idx` taken as the buffer slot number.
- R5: A violation never sets a status bit when its entry is disabled or when `res_idx` is not below the entry count (10).
- R6: In scan and buffered modes with `awd_ie`=1 and `eoc_ie`=0, `global_flag` and a one-cycle `irq` pulse appear on the edge after `seq_end` when at least one status bit is set, counting a status bit set in that same cycle. Before `seq_end`, neither appears, and `seq_end` with no status bit set raises nothing.
- R7: In scan and buffered modes with `awd_ie`=1 and `eoc_ie`=1, a status-setting violation raises `global_flag`, a one-cycle `irq` pulse and a one-cycle `stop_req` pulse on the next edge.
- R8: With `awd_ie`=0, status bits and `global_flag` update as above, but `irq` and `stop_req` stay 0.
- R9: Status bits and `global_flag` are sticky. A 1 on `clr_status[i]` or on `clr_global` clears the bit. A set in the same cycle as its clear wins, so the bit stays 1.
- R10: After reset, `status`, `global_flag`, `irq` and `stop_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 single, 1 continuous, 2 scan, 3 buffered |
| lo_thr | input | 10 | Low window limit |
| hi_thr | input | 10 | High window limit |
| entry_en | input | 10 | Per-entry enable for scan/buffered modes |
| awd_ie | input | 1 | Watchdog interrupt enable |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| res_valid | input | 1 | Result strobe |
| res_data | input | 10 | Conversion result |
| res_idx | input | 4 | Channel or buffer slot of the result |
| seq_end | input | 1 | End-of-sequence strobe |
| clr_status | input | 10 | Write-one-to-clear for status bits |
| clr_global | input | 1 | Write-one-to-clear for the global flag |
| status | output | 10 | Sticky per-entry violation status |
| global_flag | output | 1 | Sticky global watchdog flag |
| irq | output | 1 | One-cycle watchdog interrupt pulse |
| stop_req | output | 1 | One-cycle request to stop continuous conversion |

## Verification
The assertions assume that `res_idx` and `res_data` matter only while `res_valid` is high. They also assume that `mode`, the thresholds and the enables are steady for a whole sequence, with `lo_thr` no greater than `hi_thr`. The stimulus keeps to these rules. Configuration changes only after a clock edge has consumed the previous stimulus, and before the next stimulus is driven. Thresholds stay fixed with a proper window, and each sequence runs in a single mode.

// File: rtl/awd_pkg.sv
package awd_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_CONT     = 2'd1,
        MODE_SCAN     = 2'd2,
        MODE_BUFFERED = 2'd3
    } awd_mode_e;

    // True when per-entry enable/status tracking is used
    function automatic logic mode_tracks_entries(input logic [1:0] m);
        return (m == MODE_SCAN) || (m == MODE_BUFFERED);
    endfunction
endpackage

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
    parameter int DATA_W = 10
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] lo_lim,
    input  logic [DATA_W-1:0] hi_lim,
    output logic              outside
);
    logic below;
    logic above;

    always_comb begin
        below   = sample < lo_lim;
        above   = sample > hi_lim;
        outside = valid && (below || above);
    end
endmodule

// File: rtl/awd_entry_status.sv
module awd_entry_status #(
    parameter int N_ENTRIES = 10,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 track,
    input  logic                 outside,
    input  logic [IDX_W-1:0]     idx,
    input  logic [N_ENTRIES-1:0] en,
    input  logic [N_ENTRIES-1:0] clr,
    output logic [N_ENTRIES-1:0] status_q,
    output logic [N_ENTRIES-1:0] hit
);
    typedef struct packed {
        logic [N_ENTRIES-1:0] status;
    } st_t;

    st_t st_d, st_q;

    // One decoder slice per entry
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        assign hit[i] = track && outside && en[i] && (idx == MY_IDX);

        // R5
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q.status[i] && !(track && outside && en[i] && idx == MY_IDX)) |=> !st_q.status[i]);

        // R9
        status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.status[i] && !clr[i]) |=> st_q.status[i]);
    end

    always_comb begin
        st_d        = st_q;
        st_d.status = (st_q.status & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.status;
endmodule

// File: rtl/awd_event_ctrl.sv
module awd_event_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic direct,
    input  logic outside,
    input  logic hit_any,
    input  logic status_any,
    input  logic seq_end,
    input  logic awd_ie,
    input  logic eoc_ie,
    input  logic clr_global,
    output logic global_q,
    output logic irq_q,
    output logic stop_q
);
    typedef struct packed {
        logic glob;
        logic irq;
        logic stop;
    } ev_t;

    ev_t  ev_d, ev_q;
    logic immediate;
    logic raise;

    always_comb begin
        immediate = awd_ie && eoc_ie;
        if (direct)         raise = outside;
        else if (immediate) raise = hit_any;
        else                raise = seq_end && status_any;

        ev_d      = ev_q;
        ev_d.glob = (ev_q.glob && !clr_global) || raise;
        ev_d.irq  = awd_ie && raise;
        ev_d.stop = !direct && immediate && hit_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign global_q = ev_q.glob;
    assign irq_q    = ev_q.irq;
    assign stop_q   = ev_q.stop;

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(awd_ie));

    // R7
    stop_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> (irq_q && global_q));

    // R9
    global_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (global_q && !clr_global) |=> global_q);

    // R2
    direct_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && outside && awd_ie) |=> (irq_q && global_q));
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor #(
    parameter int DATA_W    = 10,
    parameter int N_ENTRIES = 10,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [DATA_W-1:0]    lo_thr,
    input  logic [DATA_W-1:0]    hi_thr,
    input  logic [N_ENTRIES-1:0] entry_en,
    input  logic                 awd_ie,
    input  logic                 eoc_ie,
    input  logic                 res_valid,
    input  logic [DATA_W-1:0]    res_data,
    input  logic [IDX_W-1:0]     res_idx,
    input  logic                 seq_end,
    input  logic [N_ENTRIES-1:0] clr_status,
    input  logic                 clr_global,
    output logic [N_ENTRIES-1:0] status,
    output logic                 global_flag,
    output logic                 irq,
    output logic                 stop_req
);
    import awd_pkg::*;

    logic                 outside;
    logic                 track;
    logic [N_ENTRIES-1:0] hit;
    logic [N_ENTRIES-1:0] status_q;

    assign track = mode_tracks_entries(mode);

    awd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .valid   (res_valid),
        .sample  (res_data),
        .lo_lim  (lo_thr),
        .hi_lim  (hi_thr),
        .outside (outside)
    );

    awd_entry_status #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .track    (track),
        .outside  (outside),
        .idx      (res_idx),
        .en       (entry_en),
        .clr      (clr_status),
        .status_q (status_q),
        .hit      (hit)
    );

    awd_event_ctrl u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct     (!track),
        .outside    (outside),
        .hit_any    (|hit),
        .status_any (|(status_q | hit)),
        .seq_end    (seq_end),
        .awd_ie     (awd_ie),
        .eoc_ie     (eoc_ie),
        .clr_global (clr_global),
        .global_q   (global_flag),
        .irq_q      (irq),
        .stop_q     (stop_req)
    );

    assign status = status_q;

    // R2
    direct_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!track && clr_status == '0) |=> $stable(status));
endmodule

// File: tb/awd_monitor_tb_top.sv
module awd_monitor_tb_top;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [9:0]   lo_thr = 10'd100;
    logic [9:0]   hi_thr = 10'd900;
    logic [N-1:0] entry_en = '0;
    logic         awd_ie = 1'b0;
    logic         eoc_ie = 1'b0;
    logic         res_valid = 1'b0;
    logic [9:0]   res_data = '0;
    logic [3:0]   res_idx = '0;
    logic         seq_end = 1'b0;
    logic [N-1:0] clr_status = '0;
    logic         clr_global = 1'b0;
    logic [N-1:0] status;
    logic         global_flag, irq, stop_req;

    always #2 clk = ~clk;  // 250 MHz

    awd_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .lo_thr(lo_thr), .hi_thr(hi_thr),
        .entry_en(entry_en), .awd_ie(awd_ie), .eoc_ie(eoc_ie),
        .res_valid(res_valid), .res_data(res_data), .res_idx(res_idx),
        .seq_end(seq_end), .clr_status(clr_status), .clr_global(clr_global),
        .status(status), .global_flag(global_flag), .irq(irq), .stop_req(stop_req)
    );

    typedef struct {
        logic [N-1:0] st;
        logic         g;
        logic         i;
        logic         s;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           checks = 0;
    int           errors = 0;
    logic [N-1:0] m_st = '0;
    logic         m_g = 1'b0;
    bit           done = 1'b0;

    // Driver: one stimulus cycle plus the expected outcome
    task automatic step(input logic [1:0] md, input logic v, input logic [9:0] d,
                        input logic [3:0] ix, input logic se, input logic [N-1:0] cs,
                        input logic cg, input string tag);
        logic         outside, direct, imm, raise;
        logic [N-1:0] hitv;
        exp_t         e;
        @(negedge clk);
        mode = md; res_valid = v; res_data = d; res_idx = ix;
        seq_end = se; clr_status = cs; clr_global = cg;
        outside = v && ((d < lo_thr) || (d > hi_thr));
        direct  = (md < 2);
        hitv    = '0;
        if (!direct && outside && ix < N && entry_en[ix]) hitv[ix] = 1'b1;
        imm = awd_ie && eoc_ie;
        if (direct)   raise = outside;
        else if (imm) raise = |hitv;
        else          raise = se && (|(m_st | hitv));
        m_st  = (m_st & ~cs) | hitv;
        m_g   = (m_g && !cg) || raise;
        e.st  = m_st; e.g = m_g; e.i = awd_ie && raise;
        e.s   = !direct && imm && (|hitv);
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    task automatic idle(input string tag);
        step(mode, 1'b0, 10'd0, 4'd0, 1'b0, '0, 1'b0, tag);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (status !== e.st || global_flag !== e.g || irq !== e.i || stop_req !== e.s) begin
                    errors++;
                    $display("FAIL %s: got st=%b g=%b i=%b s=%b exp st=%b g=%b i=%b s=%b",
                             e.tag, status, global_flag, irq, stop_req, e.st, e.g, e.i, e.s);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (status !== '0 || global_flag !== 1'b0 || irq !== 1'b0 || stop_req !== 1'b0) begin
            errors++;
            $display("FAIL R10: got st=%b g=%b i=%b s=%b exp all zero", status, global_flag, irq, stop_req);
        end
        rst_n = 1'b1;
        @(posedge clk);

        // R1 / R2: single and continuous modes
        awd_ie = 1'b1;
        entry_en = '0;
        step(2'd0, 1, 10'd100, 4'd3, 0, '0, 0, "R1 equal low");
        step(2'd0, 1, 10'd900, 4'd3, 0, '0, 0, "R1 equal high");
        step(2'd0, 1, 10'd99,  4'd3, 0, '0, 0, "R1 below low");
        idle("R9 global sticky");
        step(2'd0, 0, 10'd0, 4'd0, 0, '0, 1, "R9 global clear");
        step(2'd1, 1, 10'd901, 4'd5, 0, '0, 0, "R2 continuous above");
        step(2'd1, 1, 10'd500, 4'd5, 0, '0, 1, "R2 clear in range");

        // R3 / R5 / R6: scan, deferred reporting
        entry_en = 10'b11_1110_1111;
        eoc_ie = 1'b0;
        step(2'd2, 1, 10'd500, 4'd0, 0, '0, 0, "R3 in range ch0");
        step(2'd2, 1, 10'd50,  4'd1, 0, '0, 0, "R3 ch1 low");
        step(2'd2, 1, 10'd950, 4'd2, 0, '0, 0, "R6 no flag before end");
        step(2'd2, 1, 10'd10,  4'd4, 0, '0, 0, "R5 disabled ch4");
        step(2'd2, 1, 10'd10,  4'd12, 0, '0, 0, "R5 index out of range");
        step(2'd2, 1, 10'd500, 4'd9, 1, '0, 0, "R6 end of scan");
        step(2'd2, 1, 10'd20,  4'd1, 0, 10'b00_0000_0110, 1, "R9 clear collides");
        step(2'd2, 0, 10'd0,   4'd0, 0, 10'b00_0000_0010, 0, "R9 clear status");
        step(2'd2, 0, 10'd0,   4'd0, 1, '0, 0, "R6 end with nothing set");

        // R4: buffered
        step(2'd3, 1, 10'd960, 4'd3, 0, '0, 0, "R4 slot3 high");
        step(2'd3, 1, 10'd300, 4'd4, 1, '0, 0, "R4 end of buffer");
        step(2'd3, 1, 10'd960, 4'd7, 1, 10'b00_0000_1000, 1, "R4 R6 same-cycle hit at end");
        step(2'd3, 0, 10'd0, 4'd0, 0, '1, 1, "R9 full clear");

        // R7: immediate mode
        eoc_ie = 1'b1;
        step(2'd3, 1, 10'd5,   4'd5, 0, '0, 0, "R7 immediate hit");
        step(2'd3, 1, 10'd500, 4'd6, 0, '0, 0, "R7 pulse ends");
        step(2'd2, 1, 10'd2,   4'd4, 0, '0, 1, "R7 disabled no stop");
        step(2'd2, 0, 10'd0, 4'd0, 0, '1, 1, "R9 full clear");

        // R8: interrupt disabled
        awd_ie = 1'b0;
        step(2'd2, 1, 10'd1,   4'd8, 0, '0, 0, "R8 status without irq");
        step(2'd2, 0, 10'd0,   4'd0, 1, '0, 0, "R8 end no irq");
        step(2'd0, 1, 10'd1000, 4'd0, 0, '1, 1, "R8 single no irq");
        idle("R8 idle");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule